// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block turns a short packet into the differential line signalling used by a low-speed serial bus. It sends one line bit every `CLKS_PER_BIT` clocks (ten by default). The packet always begins with an internally generated sync byte. The bytes that follow are fetched one at a time from the user through a request strobe. Every bit goes through NRZI encoding and bit stuffing. The packet ends with an end-of-packet signal, after which the drivers are released and a one-clock completion pulse is given. CRC and the choice of packet identifier are left to the logic that supplies the bytes.

The total byte count, sync included, is given with the start strobe. The same strobe carries a packet-type flag. When a data packet completes, a pending device address is copied into the active address. After a handshake packet the active address is left alone.

Top module: `usbtx_ls_serializer`

## Requirements
- R1: While idle, and after reset, both output enables are low, both line outputs are 0, `done_o` is 0 and `dev_addr_o` is 0.
- R2: A start strobe accepted at clock edge E0 gives one clock of idle J (dp 0, dm 1) with the drivers off. Then the drivers turn on and hold J for one bit time (10 clocks) before the first sync bit.
- R3: Every line bit lasts exactly `CLKS_PER_BIT` clocks, and while driving the lines change only at bit boundaries. Bit slot k occupies cycles 11+10k to 20+10k after E0.
- R4: The sync byte 0x80 is sent first, then the user bytes in request order, each least significant bit first. The encoding is NRZI: a 0 toggles the line between J and K (K is dp 1, dm 0) and a 1 holds it.
- R5: After six consecutive 1 bits, one extra toggle is inserted. The run of 1s is counted across byte boundaries, including the boundary from sync into data. A run ending on the last bit still gets its toggle before the end of packet.
- R6: The byte count `byte_cnt_i` is clamped to the range 2 to 12, and exactly count-1 bytes are requested. `byte_req_o` is a one-clock pulse and `byte_i` is taken in that same clock. Each request is made as bit 6 of the current byte begins, so the first request comes in cycle 70 after E0.
- R7: The end of packet drives SE0 (both lines 0, drivers on) for 20 clocks, then J for 10 clocks. After that the drivers are off and both lines are 0.
- R8: `done_o` is high for exactly one clock: the first clock in which the drivers are released.
- R9: A start strobe that arrives while a packet is in progress has no effect on the line waveform.
- R10: `dev_addr_o` takes the value of `new_addr_i` in the release clock only when `pkt_data_i` was 1 at start. After a packet started with `pkt_data_i` at 0 (a handshake), it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a packet (taken only while idle) |
| byte_cnt_i | input | 4 | Bytes in the packet, sync included |
| pkt_data_i | input | 1 | 1 for a data packet, 0 for a handshake |
| new_addr_i | input | 7 | Pending device address |
| byte_req_o | output | 1 | One-clock request for the next byte |
| byte_i | input | 8 | Byte value, taken while byte_req_o is high |
| dp_o | output | 1 | D+ line value |
| dm_o | output | 1 | D- line value |
| dp_oe_o | output | 1 | D+ driver enable |
| dm_oe_o | output | 1 | D- driver enable |
| done_o | output | 1 | One-clock pulse when the bus is released |
| dev_addr_o | output | 7 | Active device address |

## Verification
All timing is counted from E0, the edge that accepts start. The drivers turn on at cycle 1. Line bit k is due from cycle 11+10k. SE0 starts at 11+10L, where L is the total number of line bits including stuffed ones. The J bit starts at 31+10L, done and release fall in cycle 41+10L, and the new address is visible from that same cycle. The bench builds its own expected line-level list from the byte list and checks the first, middle and last clock of every bit slot. Each of the other events is checked exactly in the cycle computed above, sampled on the falling edge.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  localparam int unsigned MIN_BYTES = 2;
  localparam int unsigned MAX_BYTES = 12;
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);
  localparam logic [7:0]  SYNC_BYTE = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LEAD, ST_SEND, ST_SE0, ST_EOPJ, ST_REL
  } tx_state_e;

  // keep requested count inside the legal window
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] n);
    if (n < CNT_W'(MIN_BYTES))      return CNT_W'(MIN_BYTES);
    else if (n > CNT_W'(MAX_BYTES)) return CNT_W'(MAX_BYTES);
    else                            return n;
  endfunction

  // NRZI: a one keeps the level, a zero flips it (level coded as 1 = J)
  function automatic logic nrzi_level(input logic cur_j, input logic bit_v);
    return bit_v ? cur_j : ~cur_j;
  endfunction
endpackage

// File: rtl/usbtx_slot_timer.sv
module usbtx_slot_timer #(
  parameter int unsigned CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic slot_end_o
);
  localparam int unsigned DIV_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_BIT - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (!run_i)         div_q <= '0;
    else if (div_q == LAST)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign slot_end_o = run_i && (div_q == LAST);
endmodule

// File: rtl/usbtx_byte_feed.sv
module usbtx_byte_feed
  import usbtx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              req_o,
  output logic              bit_o,
  output logic              have_bit_o
);
  localparam int unsigned BL_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q, nxt_q;
  logic [BL_W-1:0]   bits_left_q;
  logic [CNT_W-1:0]  bytes_left_q;
  logic              more_bytes;

  assign more_bytes = (bytes_left_q != '0);
  // ask for the next byte as the second to last bit begins
  assign req_o      = take_i && (bits_left_q == BL_W'(2)) && more_bytes;
  assign bit_o      = sh_q[0];
  assign have_bit_o = (bits_left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q         <= '0;
      bits_left_q  <= '0;
      bytes_left_q <= '0;
    end else if (load_i) begin
      sh_q         <= BYTE_W'(SYNC_BYTE);
      bits_left_q  <= BL_W'(BYTE_W);
      bytes_left_q <= clamp_count(cnt_i) - 1'b1;
    end else if (take_i) begin
      if ((bits_left_q == BL_W'(1)) && more_bytes) begin
        sh_q         <= nxt_q;
        bits_left_q  <= BL_W'(BYTE_W);
        bytes_left_q <= bytes_left_q - 1'b1;
      end else begin
        sh_q        <= sh_q >> 1;
        bits_left_q <= bits_left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nxt_q <= '0;
    else if (req_o) nxt_q <= byte_i;
  end
endmodule

// File: rtl/usbtx_nrzi_stuffer.sv
module usbtx_nrzi_stuffer
  import usbtx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic take_i,
  input  logic stuff_i,
  input  logic bit_i,
  output logic line_j_o,
  output logic stuff_due_o
);
  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);

  logic [RUN_W-1:0] ones_q;
  logic             line_j_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_j_q <= 1'b1;
      ones_q   <= '0;
    end else if (clear_i) begin
      line_j_q <= 1'b1;
      ones_q   <= '0;
    end else if (stuff_i) begin
      line_j_q <= ~line_j_q;
      ones_q   <= '0;
    end else if (take_i) begin
      line_j_q <= nrzi_level(line_j_q, bit_i);
      ones_q   <= bit_i ? ones_q + 1'b1 : '0;
    end
  end

  assign line_j_o    = line_j_q;
  assign stuff_due_o = (ones_q == RUN_W'(STUFF_RUN));
endmodule

// File: rtl/usbtx_ls_serializer.sv
module usbtx_ls_serializer
  import usbtx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 10,
  parameter int unsigned STUFF_RUN    = 6,
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              pkt_data_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic              byte_req_o,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              dp_oe_o,
  output logic              dm_oe_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  tx_state_e state_q;
  logic      is_data_q, se0_half_q;
  logic      accept, run, slot_end, adv;
  logic      stuff_due, have_bit, cur_bit, line_j;
  logic      take, stuff, finish, busy;
  logic      drv_en;

  // named internal events
  assign accept = (state_q == ST_IDLE) && start_i;
  assign run    = (state_q == ST_LEAD) || (state_q == ST_SEND) ||
                  (state_q == ST_SE0)  || (state_q == ST_EOPJ);
  assign busy   = (state_q != ST_IDLE);
  assign adv    = slot_end && ((state_q == ST_LEAD) || (state_q == ST_SEND));
  assign stuff  = adv && stuff_due;
  assign take   = adv && !stuff_due && have_bit;
  assign finish = adv && !stuff_due && !have_bit;

  usbtx_slot_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .slot_end_o(slot_end)
  );

  usbtx_byte_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .cnt_i(byte_cnt_i),
    .take_i(take), .byte_i(byte_i), .req_o(byte_req_o),
    .bit_o(cur_bit), .have_bit_o(have_bit)
  );

  usbtx_nrzi_stuffer #(.STUFF_RUN(STUFF_RUN)) u_enc (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .take_i(take),
    .stuff_i(stuff), .bit_i(cur_bit), .line_j_o(line_j),
    .stuff_due_o(stuff_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      is_data_q  <= 1'b0;
      se0_half_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_ARM;
          is_data_q <= pkt_data_i;
        end
        ST_ARM:  state_q <= ST_LEAD;
        ST_LEAD: if (slot_end) state_q <= ST_SEND;
        ST_SEND: if (finish) begin
          state_q    <= ST_SE0;
          se0_half_q <= 1'b0;
        end
        ST_SE0: if (slot_end) begin
          if (se0_half_q) state_q <= ST_EOPJ;
          else            se0_half_q <= 1'b1;
        end
        ST_EOPJ: if (slot_end) state_q <= ST_REL;
        ST_REL:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // active address moves only after a data packet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 dev_addr_o <= '0;
    else if ((state_q == ST_EOPJ) && slot_end && is_data_q)
                                                dev_addr_o <= new_addr_i;
  end

  always_comb begin
    drv_en = 1'b0;
    dp_o   = 1'b0;
    dm_o   = 1'b0;
    case (state_q)
      ST_ARM:  begin dm_o = 1'b1; end
      ST_LEAD, ST_SEND: begin
        drv_en = 1'b1;
        dp_o   = ~line_j;
        dm_o   = line_j;
      end
      ST_SE0:  begin drv_en = 1'b1; end
      ST_EOPJ: begin drv_en = 1'b1; dm_o = 1'b1; end
      default: ;
    endcase
  end

  assign dp_oe_o = drv_en;
  assign dm_oe_o = drv_en;
  assign done_o  = (state_q == ST_REL);
endmodule

// File: rtl/usbtx_checker.sv
module usbtx_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp_o,
  input logic              dm_o,
  input logic              dp_oe_o,
  input logic              dm_oe_o,
  input logic              done_o,
  input logic              byte_req_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic              slot_end,
  input logic              busy
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!dp_oe_o && !dm_oe_o && !dp_o && !dm_o));

  a_r2_take_bus_in_j: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_oe_o) |-> (dm_o && !dp_o));

  a_r2_j_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_oe_o) |-> $past(dm_o && !dp_o));

  a_r3_change_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_oe_o && $past(dp_oe_o) && !$stable(dm_o)) |-> $past(slot_end));

  a_r6_req_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_o |-> (busy && dp_oe_o));

  a_r7_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
    dp_oe_o == dm_oe_o);

  a_r10_addr_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(dev_addr_o));
endmodule

bind usbtx_ls_serializer usbtx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp_o(dp_o), .dm_o(dm_o),
  .dp_oe_o(dp_oe_o), .dm_oe_o(dm_oe_o), .done_o(done_o),
  .byte_req_o(byte_req_o), .dev_addr_o(dev_addr_o),
  .slot_end(slot_end), .busy(busy)
);

// File: tb/sim_usbtx_ls_serializer.sv
module sim_usbtx_ls_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] byte_cnt_i = '0;
  logic       pkt_data_i = 1'b0;
  logic [6:0] new_addr_i = '0;
  logic       byte_req_o;
  logic [7:0] byte_i;
  logic       dp_o, dm_o, dp_oe_o, dm_oe_o, done_o;
  logic [6:0] dev_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pkt [0:15];
  logic       exp_lvl [0:159];
  int         idx_q = 0;
  logic       idx_clr = 1'b0;
  logic [6:0] addr_exp = '0;

  always #5 clk = ~clk;

  usbtx_ls_serializer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .pkt_data_i(pkt_data_i), .new_addr_i(new_addr_i), .byte_req_o(byte_req_o),
    .byte_i(byte_i), .dp_o(dp_o), .dm_o(dm_o), .dp_oe_o(dp_oe_o),
    .dm_oe_o(dm_oe_o), .done_o(done_o), .dev_addr_o(dev_addr_o)
  );

  assign byte_i = pkt[idx_q[3:0]];

  always @(posedge clk) begin
    if (idx_clr)         idx_q <= 0;
    else if (byte_req_o) idx_q <= idx_q + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // own model of the line levels, one entry per bit slot (1 = J)
  function automatic int build_levels(input int nbytes);
    int   n = 0;
    int   ones = 0;
    logic lvl = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] v = (b == 0) ? 8'h80 : pkt[b-1];
      for (int i = 0; i < 8; i++) begin
        if (ones == 6) begin lvl = ~lvl; ones = 0; exp_lvl[n] = lvl; n++; end
        if (v[i]) ones++; else begin lvl = ~lvl; ones = 0; end
        exp_lvl[n] = lvl; n++;
      end
    end
    if (ones == 6) begin lvl = ~lvl; exp_lvl[n] = lvl; n++; end
    return n;
  endfunction

  task automatic send(input string tag, input int cnt, input logic is_data,
                      input logic [6:0] addr, input logic glitch);
    int nb;
    int len;
    int first_req = -1;
    int reqs = 0;
    nb = (cnt < 2) ? 2 : ((cnt > 12) ? 12 : cnt);
    len = build_levels(nb);
    @(negedge clk);
    idx_clr = 1'b1;
    @(negedge clk);
    idx_clr    = 1'b0;
    byte_cnt_i = 4'(cnt);
    pkt_data_i = is_data;
    new_addr_i = addr;
    start_i    = 1'b1;
    @(posedge clk);                      // edge E0
    for (int t = 0; t <= 42 + 10*len; t++) begin
      @(negedge clk);
      start_i = glitch && (t == 30 || t == 10*len);   // R9 stimulus
      if (byte_req_o) begin
        reqs++;
        if (first_req < 0) first_req = t;
      end
      check({tag, " R8 done"}, done_o, (t == 41 + 10*len) ? 1 : 0);
      if (t == 0) begin
        check({tag, " R2 arm dm"}, dm_o, 1);
        check({tag, " R2 arm dp"}, dp_o, 0);
        check({tag, " R2 arm oe"}, dp_oe_o, 0);
      end else if (t == 1 || t == 10) begin
        check({tag, " R2 lead J"}, {dp_oe_o, dm_oe_o, dp_o, dm_o}, 4'b1101);
      end
      for (int k = 0; k < len; k++) begin
        if (t == 11 + 10*k || t == 16 + 10*k || t == 20 + 10*k)
          check({tag, " R3 R4 R5 slot"}, {dp_oe_o, dp_o, dm_o},
                {1'b1, ~exp_lvl[k], exp_lvl[k]});
      end
      if (t == 11 + 10*len || t == 30 + 10*len)
        check({tag, " R7 se0"}, {dp_oe_o, dp_o, dm_o}, 3'b100);
      if (t == 31 + 10*len || t == 40 + 10*len)
        check({tag, " R7 eop J"}, {dp_oe_o, dp_o, dm_o}, 3'b101);
      if (t == 41 + 10*len)
        check({tag, " R7 release"}, {dp_oe_o, dm_oe_o, dp_o, dm_o}, 4'b0000);
      if (t == 41 + 10*len) begin
        if (is_data) addr_exp = addr;
        check({tag, " R10 addr"}, dev_addr_o, addr_exp);
      end
    end
    start_i = 1'b0;
    check({tag, " R6 request count"}, reqs, nb - 1);
    check({tag, " R6 first request cycle"}, first_req, 70);
    check({tag, " R1 idle after"}, {dp_oe_o, dp_o, dm_o, done_o}, 4'b0000);
  endtask

  task automatic t_reset;
    check("R1 reset oe", {dp_oe_o, dm_oe_o}, 0);
    check("R1 reset lines", {dp_o, dm_o}, 0);
    check("R1 reset done", done_o, 0);
    check("R1 reset addr", dev_addr_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) pkt[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    pkt[0] = 8'hD2;
    send("ack handshake", 2, 1'b0, 7'h05, 1'b0);

    pkt[0] = 8'hC3; pkt[1] = 8'h00; pkt[2] = 8'hFF;
    send("data with ones", 4, 1'b1, 7'h2A, 1'b0);

    pkt[0] = 8'hFF; pkt[1] = 8'hFF;
    send("stuff across sync", 3, 1'b0, 7'h11, 1'b0);

    pkt[0] = 8'hFC;
    send("trailing stuff with start glitch", 2, 1'b0, 7'h33, 1'b1);

    pkt[0] = 8'h5A;
    send("count below range", 0, 1'b1, 7'h44, 1'b0);

    for (int i = 0; i < 16; i++) pkt[i] = 8'(i * 91 + 3);
    pkt[4] = 8'hFF; pkt[5] = 8'h7F;
    send("count above range", 15, 1'b1, 7'h7F, 1'b0);

    send("full length glitch", 12, 1'b0, 7'h01, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule